// File: doc/BRIEF.md
# Routed Local Interrupt Controller

This block collects up to 32 asynchronous interrupt sources from nearby peripherals and presents them to a small cluster of cores. Each source is first brought into the clock domain through a synchronizer. It is then judged as either level-sensitive or edge-latched, with a programmable active sense. Software reaches the block over a simple 32-bit register bus with byte strobes. Through that bus it sets the sense and mode of each source, switches sources on and off through separate set and clear registers, reads the status of enabled pending sources, and acknowledges latched edges.

Every source owns one route byte. The low nibble names the cores that should see the source. The high nibble names which of the four parent lines carries it on those cores. The outputs form a grid of parent lines, four for each core. A line is raised whenever any enabled pending source is routed to that core and that parent line. A source routed to several cores raises the same parent line on each of them.

Top module: `rlic_top`

## Requirements
- R1: After reset the enable mask, polarity register, mode register and all route bytes read as zero, status reads zero and every `irq_o` bit is low.
- R2: The route byte of source n sits at byte offset n, inside the word at offset 4*(n/4), lane n%4 (data bits 8*(n%4)+7 down to 8*(n%4)). It is written under its byte strobe only and reads back unchanged.
- R3: Writing to offset 0x28 sets every enable bit whose strobed data bit is 1 and leaves every other enable bit unchanged. Offset 0x24 reads the enable mask, with bit n for source n.
- R4: Writing to offset 0x2C clears every enable bit whose strobed data bit is 1 and leaves the others unchanged, so an all-ones write disables every source.
- R5: Offset 0x30 holds polarity (1 = active-high or rising, 0 = active-low or falling) and offset 0x34 holds mode (1 = edge, 0 = level). Both are read/write under byte strobes.
- R6: In level mode a source is pending exactly while its synchronized input is at its active level. Nothing is latched.
- R7: In edge mode a transition of the synchronized input into its active level sets a sticky pending bit. The bit stays set until a 1 is written to its position at offset 0x40; a 0 in that position leaves it set.
- R8: Offset 0x40 reads the pending bits of enabled sources only, with bit n for source n.
- R9: Output bit `irq_o[4*c + p]` is the OR of all enabled pending sources whose route byte has bit c and bit 4+p set, delivered one clock after the pending state. A route byte with several core bits raises the line on every named core.
- R10: A source whose enable bit is 0 never drives any output, however its input moves.
- R11: Reads of offsets that hold no readable register (0x20, 0x28, 0x2C, 0x38, 0x3C, 0x44 and above) return zero, and writes to unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr_i | input | 1 | Register write strobe, one cycle per write |
| bus_addr_i | input | 8 | Byte offset of the access (word aligned) |
| bus_wdata_i | input | 32 | Write data |
| bus_wstrb_i | input | 4 | Byte lane enables for writes |
| bus_rdata_o | output | 32 | Read data for the current offset, combinational |
| src_i | input | 32 | Raw interrupt source inputs, may be asynchronous |
| irq_o | output | 16 | Parent lines, bit 4*core + parent |

## Verification
The assertions assume that `bus_addr_i` and the strobes are stable and known whenever `bus_wr_i` is high, and that only one register is touched per cycle. The bench writes for exactly one clock with the address held, and parks the address on an unmapped offset between accesses. The sticky-edge and output checks also assume that the raw sources hold each level for more than one clock, so the synchronizer cannot swallow a pulse. The bench holds every source change for at least three cycles and samples results only after the synchronizer, edge and output registers have settled.

// File: rtl/rlic_pkg.sv
package rlic_pkg;

   localparam int ADDR_W = 8;

   typedef logic [7:0] route_t;

   localparam logic [ADDR_W-1:0] OFF_ROUTE_END = 8'h20;
   localparam logic [ADDR_W-1:0] OFF_EN_STAT   = 8'h24;
   localparam logic [ADDR_W-1:0] OFF_EN_SET    = 8'h28;
   localparam logic [ADDR_W-1:0] OFF_EN_CLR    = 8'h2C;
   localparam logic [ADDR_W-1:0] OFF_POL       = 8'h30;
   localparam logic [ADDR_W-1:0] OFF_MODE      = 8'h34;
   localparam logic [ADDR_W-1:0] OFF_STATUS    = 8'h40;

   function automatic logic [31:0] strb_mask(input logic [3:0] strb);
      logic [31:0] m;
      for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{strb[b]}};
      return m;
   endfunction

endpackage

// File: rtl/rlic_src_cell.sv
module rlic_src_cell #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   input  logic pol_i,
   input  logic mode_i,
   input  logic clr_i,
   output logic pend_o
);

   logic sync_s;
   logic active_s;
   logic prev_q;
   logic latch_q;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("rlic_src_cell: SYNC_STAGES must be at least 2");
   end

   if (SYNC_STAGES == 2) begin : g_sync2
      logic meta_q, stab_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            meta_q <= 1'b0;
            stab_q <= 1'b0;
         end else begin
            meta_q <= raw_i;
            stab_q <= meta_q;
         end
      end
      assign sync_s = stab_q;
   end else begin : g_syncn
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[SYNC_STAGES-2:0], raw_i};
      end
      assign sync_s = chain_q[SYNC_STAGES-1];
   end

   assign active_s = pol_i ? sync_s : ~sync_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         latch_q <= 1'b0;
      end else begin
         prev_q <= active_s;
         if (!mode_i)                    latch_q <= 1'b0;
         else if (active_s && !prev_q)   latch_q <= 1'b1;
         else if (clr_i)                 latch_q <= 1'b0;
      end
   end

   assign pend_o = mode_i ? latch_q : active_s;

   // R7
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i && $past(mode_i) && $past(pend_o) && !$past(clr_i)) |-> pend_o);

endmodule

// File: rtl/rlic_regs.sv
module rlic_regs
   import rlic_pkg::*;
#(
   parameter int NUM_SRC = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_i,
   input  logic [ADDR_W-1:0]        addr_i,
   input  logic [31:0]              wdata_i,
   input  logic [3:0]               wstrb_i,
   input  logic [NUM_SRC-1:0]       stat_i,
   output logic [31:0]              rdata_o,
   output route_t [NUM_SRC-1:0]     route_o,
   output logic [NUM_SRC-1:0]       en_o,
   output logic [NUM_SRC-1:0]       pol_o,
   output logic [NUM_SRC-1:0]       mode_o,
   output logic [NUM_SRC-1:0]       stat_clr_o
);

   localparam int LANES = 4;

   logic [31:0]        wmask;
   logic [NUM_SRC-1:0] wbits;
   logic [NUM_SRC-1:0] smask;
   logic               in_route;
   logic [2:0]         word_idx;
   logic               hit_set, hit_clr, hit_pol, hit_mode, hit_stat;
   logic [NUM_SRC-1:0] en_q, pol_q, mode_q;
   route_t [NUM_SRC-1:0] route_q;

   assign wmask    = strb_mask(wstrb_i);
   assign wbits    = wdata_i[NUM_SRC-1:0] & wmask[NUM_SRC-1:0];
   assign smask    = wmask[NUM_SRC-1:0];
   assign in_route = (addr_i < OFF_ROUTE_END) && (addr_i[1:0] == 2'b00);
   assign word_idx = addr_i[4:2];
   assign hit_set  = wr_i && (addr_i == OFF_EN_SET);
   assign hit_clr  = wr_i && (addr_i == OFF_EN_CLR);
   assign hit_pol  = wr_i && (addr_i == OFF_POL);
   assign hit_mode = wr_i && (addr_i == OFF_MODE);
   assign hit_stat = wr_i && (addr_i == OFF_STATUS);

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_route
      localparam int LANE = s % LANES;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            route_q[s] <= '0;
         else if (wr_i && in_route && word_idx == 3'(s / LANES) && wstrb_i[LANE])
            route_q[s] <= wdata_i[8*LANE +: 8];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         pol_q  <= '0;
         mode_q <= '0;
      end else begin
         if (hit_set)  en_q   <= en_q | wbits;
         if (hit_clr)  en_q   <= en_q & ~wbits;
         if (hit_pol)  pol_q  <= (pol_q & ~smask) | wbits;
         if (hit_mode) mode_q <= (mode_q & ~smask) | wbits;
      end
   end

   assign stat_clr_o = hit_stat ? wbits : '0;
   assign route_o    = route_q;
   assign en_o       = en_q;
   assign pol_o      = pol_q;
   assign mode_o     = mode_q;

   always_comb begin
      route_t [31:0] route_pad;
      logic   [4:0]  bidx;
      route_pad = '0;
      for (int s = 0; s < NUM_SRC; s++) route_pad[s] = route_q[s];
      rdata_o = '0;
      if (in_route) begin
         for (int j = 0; j < LANES; j++) begin
            bidx = {word_idx, 2'(j)};
            rdata_o[8*j +: 8] = route_pad[bidx];
         end
      end else begin
         case (addr_i)
            OFF_EN_STAT: rdata_o = 32'(en_q);
            OFF_POL:     rdata_o = 32'(pol_q);
            OFF_MODE:    rdata_o = 32'(mode_q);
            OFF_STATUS:  rdata_o = 32'(stat_i);
            default:     rdata_o = '0;
         endcase
      end
   end

   // R3
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_set |=> (((en_q & $past(wbits)) == $past(wbits)) &&
                   ((en_q & ~$past(wbits)) == ($past(en_q) & ~$past(wbits)))));

   // R4
   en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_clr |=> (((en_q & $past(wbits)) == '0) &&
                   ((en_q & ~$past(wbits)) == ($past(en_q) & ~$past(wbits)))));

endmodule

// File: rtl/rlic_router.sv
module rlic_router
   import rlic_pkg::*;
#(
   parameter int NUM_SRC    = 32,
   parameter int NUM_CORE   = 4,
   parameter int NUM_PARENT = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_SRC-1:0]             act_i,
   input  route_t [NUM_SRC-1:0]           route_i,
   output logic [NUM_CORE*NUM_PARENT-1:0] irq_o
);

   localparam int NUM_OUT = NUM_CORE * NUM_PARENT;

   logic [NUM_CORE-1:0][NUM_SRC-1:0]   core_sel;
   logic [NUM_PARENT-1:0][NUM_SRC-1:0] par_sel;
   logic [NUM_OUT-1:0]                 irq_d;
   logic [NUM_OUT-1:0]                 irq_q;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      for (genvar c = 0; c < NUM_CORE; c++) begin : g_c
         assign core_sel[c][s] = route_i[s][c];
      end
      for (genvar p = 0; p < NUM_PARENT; p++) begin : g_p
         assign par_sel[p][s] = route_i[s][4+p];
      end
   end

   for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
      for (genvar p = 0; p < NUM_PARENT; p++) begin : g_line
         assign irq_d[c*NUM_PARENT + p] = |(act_i & core_sel[c] & par_sel[p]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= '0;
      else        irq_q <= irq_d;
   end

   assign irq_o = irq_q;

   // R9
   out_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_q) |-> $past(|act_i));

endmodule

// File: rtl/rlic_top.sv
module rlic_top
   import rlic_pkg::*;
#(
   parameter int NUM_SRC     = 32,
   parameter int NUM_CORE    = 4,
   parameter int NUM_PARENT  = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           bus_wr_i,
   input  logic [7:0]                     bus_addr_i,
   input  logic [31:0]                    bus_wdata_i,
   input  logic [3:0]                     bus_wstrb_i,
   output logic [31:0]                    bus_rdata_o,
   input  logic [NUM_SRC-1:0]             src_i,
   output logic [NUM_CORE*NUM_PARENT-1:0] irq_o
);

   if (NUM_SRC < 1 || NUM_SRC > 32) begin : g_bad_src
      $error("rlic_top: NUM_SRC must lie in 1..32");
   end
   if (NUM_CORE < 1 || NUM_CORE > 4) begin : g_bad_core
      $error("rlic_top: NUM_CORE must lie in 1..4");
   end
   if (NUM_PARENT < 1 || NUM_PARENT > 4) begin : g_bad_par
      $error("rlic_top: NUM_PARENT must lie in 1..4");
   end

   route_t [NUM_SRC-1:0] route_w;
   logic [NUM_SRC-1:0]   en_w, pol_w, mode_w, clr_w, pend_w, act_w;

   rlic_regs #(.NUM_SRC(NUM_SRC)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (bus_wr_i),
      .addr_i    (bus_addr_i),
      .wdata_i   (bus_wdata_i),
      .wstrb_i   (bus_wstrb_i),
      .stat_i    (act_w),
      .rdata_o   (bus_rdata_o),
      .route_o   (route_w),
      .en_o      (en_w),
      .pol_o     (pol_w),
      .mode_o    (mode_w),
      .stat_clr_o(clr_w)
   );

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_cell
      rlic_src_cell #(.SYNC_STAGES(SYNC_STAGES)) cell_i (
         .clk   (clk),
         .rst_n (rst_n),
         .raw_i (src_i[s]),
         .pol_i (pol_w[s]),
         .mode_i(mode_w[s]),
         .clr_i (clr_w[s]),
         .pend_o(pend_w[s])
      );
   end

   assign act_w = pend_w & en_w;

   rlic_router #(
      .NUM_SRC   (NUM_SRC),
      .NUM_CORE  (NUM_CORE),
      .NUM_PARENT(NUM_PARENT)
   ) router_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .act_i  (act_w),
      .route_i(route_w),
      .irq_o  (irq_o)
   );

   // R10
   idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en_w) == '0) |-> (irq_o == '0));

endmodule

// File: tb/rlic_top_tb_top.sv
module rlic_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h3C;
   logic [31:0] bus_wdata = '0;
   logic [3:0]  bus_wstrb = '0;
   logic [31:0] bus_rdata;
   logic [31:0] src = '0;
   logic [15:0] irq;

   int  n_run = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #5 clk = ~clk;

   rlic_top dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_wr_i   (bus_wr),
      .bus_addr_i (bus_addr),
      .bus_wdata_i(bus_wdata),
      .bus_wstrb_i(bus_wstrb),
      .bus_rdata_o(bus_rdata),
      .src_i      (src),
      .irq_o      (irq)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic bus_w(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 8'h3C; bus_wdata = '0; bus_wstrb = '0;
   endtask

   task automatic bus_r(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
      bus_addr = 8'h3C;
   endtask

   task automatic settle();
      repeat (6) @(negedge clk);
   endtask

   task automatic cleanup();
      bus_w(8'h2C, 32'hFFFF_FFFF, 4'hF);
      src = '0;
      bus_w(8'h30, 32'h0, 4'hF);
      bus_w(8'h34, 32'h0, 4'hF);
      for (int w = 0; w < 8; w++) bus_w(8'(4*w), 32'h0, 4'hF);
      bus_w(8'h40, 32'hFFFF_FFFF, 4'hF);
      settle();
   endtask

   task automatic t_reset();
      logic [31:0] d;
      for (int w = 0; w < 8; w++) begin
         bus_r(8'(4*w), d);
         chk("R1", "route word after reset", d, 32'h0);
      end
      bus_r(8'h24, d); chk("R1", "enable after reset", d, 32'h0);
      bus_r(8'h30, d); chk("R1", "polarity after reset", d, 32'h0);
      bus_r(8'h34, d); chk("R1", "mode after reset", d, 32'h0);
      bus_r(8'h40, d); chk("R1", "status after reset", d, 32'h0);
      chk("R1", "irq after reset", 32'(irq), 32'h0);
   endtask

   task automatic t_route();
      logic [31:0] d;
      bus_w(8'h04, 32'hA1B2_C3D4, 4'hF);
      bus_r(8'h04, d); chk("R2", "route word 1 full write", d, 32'hA1B2_C3D4);
      bus_w(8'h04, 32'h1122_3344, 4'b0100);
      bus_r(8'h04, d); chk("R2", "route lane 2 only", d, 32'hA122_C3D4);
      bus_w(8'h1C, 32'h8800_0000, 4'b1000);
      bus_r(8'h1C, d); chk("R2", "route source 31 lane 3", d, 32'h8800_0000);
      bus_r(8'h00, d); chk("R2", "neighbour word untouched", d, 32'h0);
      bus_w(8'h38, 32'hFFFF_FFFF, 4'hF);
      bus_r(8'h04, d); chk("R11", "unmapped write keeps route", d, 32'hA122_C3D4);
      bus_r(8'h30, d); chk("R11", "unmapped write keeps polarity", d, 32'h0);
      cleanup();
   endtask

   task automatic t_enable();
      logic [31:0] d;
      bus_w(8'h28, 32'h0000_00F0, 4'hF);
      bus_r(8'h24, d); chk("R3", "set F0", d, 32'h0000_00F0);
      bus_w(8'h28, 32'h0F00_0000, 4'hF);
      bus_r(8'h24, d); chk("R3", "set keeps others", d, 32'h0F00_00F0);
      bus_w(8'h2C, 32'h0000_0030, 4'hF);
      bus_r(8'h24, d); chk("R4", "clear 30", d, 32'h0F00_00C0);
      bus_w(8'h28, 32'hFFFF_FFFF, 4'b0001);
      bus_r(8'h24, d); chk("R3", "set under lane 0 strobe", d, 32'h0F00_00FF);
      bus_r(8'h28, d); chk("R11", "set register reads zero", d, 32'h0);
      bus_r(8'h2C, d); chk("R11", "clear register reads zero", d, 32'h0);
      bus_w(8'h2C, 32'hFFFF_FFFF, 4'hF);
      bus_r(8'h24, d); chk("R4", "all-ones clear", d, 32'h0);
      bus_w(8'h30, 32'hDEAD_BEEF, 4'b0011);
      bus_r(8'h30, d); chk("R5", "polarity strobed", d, 32'h0000_BEEF);
      bus_w(8'h34, 32'h1234_5678, 4'b1100);
      bus_r(8'h34, d); chk("R5", "mode strobed", d, 32'h1234_0000);
      bus_r(8'h20, d); chk("R11", "offset 20 reads zero", d, 32'h0);
      bus_r(8'h3C, d); chk("R11", "offset 3C reads zero", d, 32'h0);
      bus_r(8'h44, d); chk("R11", "offset 44 reads zero", d, 32'h0);
      cleanup();
   endtask

   task automatic t_level();
      logic [31:0] d;
      bus_w(8'h00, 32'h4200_0000, 4'b1000);
      bus_w(8'h30, 32'h0000_0008, 4'hF);
      bus_w(8'h28, 32'h0000_0008, 4'hF);
      settle();
      bus_r(8'h40, d); chk("R6", "level idle", d, 32'h0);
      @(negedge clk); src[3] = 1'b1;
      settle();
      bus_r(8'h40, d); chk("R6", "level high pending", d, 32'h0000_0008);
      chk("R9", "core1 parent2 raised", 32'(irq), 32'h0000_0040);
      @(negedge clk); src[3] = 1'b0;
      settle();
      bus_r(8'h40, d); chk("R6", "level released", d, 32'h0);
      chk("R6", "line dropped", 32'(irq), 32'h0);
      bus_w(8'h04, 32'h0000_1800, 4'b0010);
      bus_w(8'h28, 32'h0000_0020, 4'hF);
      settle();
      bus_r(8'h40, d); chk("R5", "active-low source pending", d, 32'h0000_0020);
      chk("R9", "core3 parent0 raised", 32'(irq), 32'h0000_1000);
      @(negedge clk); src[5] = 1'b1;
      settle();
      chk("R5", "active-low released", 32'(irq), 32'h0);
      cleanup();
   endtask

   task automatic t_edge();
      logic [31:0] d;
      bus_w(8'h08, 32'h0000_2111, 4'b0011);
      bus_w(8'h30, 32'h0000_0100, 4'hF);
      bus_w(8'h34, 32'h0000_0300, 4'hF);
      bus_w(8'h28, 32'h0000_0300, 4'hF);
      settle();
      bus_r(8'h40, d); chk("R7", "edge idle", d, 32'h0);
      @(negedge clk); src[8] = 1'b1;
      repeat (3) @(negedge clk); src[8] = 1'b0;
      settle();
      bus_r(8'h40, d); chk("R7", "rising edge latched", d, 32'h0000_0100);
      chk("R9", "core0 parent0 raised", 32'(irq), 32'h0000_0001);
      bus_w(8'h40, 32'h0000_0000, 4'hF);
      settle();
      bus_r(8'h40, d); chk("R7", "zero write keeps latch", d, 32'h0000_0100);
      bus_w(8'h40, 32'h0000_0100, 4'hF);
      settle();
      bus_r(8'h40, d); chk("R7", "acknowledge clears", d, 32'h0);
      chk("R7", "line dropped after ack", 32'(irq), 32'h0);
      @(negedge clk); src[9] = 1'b1;
      settle();
      bus_r(8'h40, d); chk("R7", "falling source raised, no edge", d, 32'h0);
      @(negedge clk); src[9] = 1'b0;
      settle();
      bus_r(8'h40, d); chk("R7", "falling edge latched", d, 32'h0000_0200);
      chk("R9", "core0 parent1 raised", 32'(irq), 32'h0000_0002);
      cleanup();
   endtask

   task automatic t_multi();
      logic [31:0] d;
      bus_w(8'h0C, 32'h0000_0085, 4'b0001);
      bus_w(8'h30, 32'h0010_1000, 4'hF);
      bus_w(8'h50, 32'h0000_0011, 4'b0001);
      bus_w(8'h14, 32'h0000_0011, 4'b0001);
      @(negedge clk); src[12] = 1'b1; src[20] = 1'b1;
      settle();
      bus_r(8'h40, d); chk("R8", "disabled sources hidden", d, 32'h0);
      chk("R10", "disabled sources drive nothing", 32'(irq), 32'h0);
      bus_w(8'h28, 32'h0000_1000, 4'hF);
      settle();
      bus_r(8'h40, d); chk("R8", "only enabled source shown", d, 32'h0000_1000);
      chk("R9", "two cores parent3", 32'(irq), 32'h0000_0808);
      bus_w(8'h28, 32'h0010_0000, 4'hF);
      settle();
      chk("R9", "merged lines", 32'(irq), 32'h0000_0809);
      bus_w(8'h2C, 32'h0000_1000, 4'hF);
      settle();
      chk("R10", "disable removes source", 32'(irq), 32'h0000_0001);
      cleanup();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_route();
      t_enable();
      t_level();
      t_edge();
      t_multi();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #1500000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL all: watchdog actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule